// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the execute stage of a 32-bit integer pipeline for data-processing operations. It performs one operation per cycle. Operand 2 first goes through a logical left shift by an immediate amount. The shifted value then enters one shared adder or a bitwise unit, which computes the result. A four-bit flag register holds negative, zero, carry and overflow (NZCV). Each cycle, the instruction either writes new values into this register or leaves it unchanged.

The carry-using operations take the stored carry flag as carry-in. This lets software chain wide arithmetic across 32-bit words. Subtraction treats the carry as NOT borrow. The comparison and test operations change only the flags and never request a destination write. A register file sits outside the block and captures `result` whenever `writeDest` is high.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 gives opA + shifted opB. Opcode 1 gives opA + shifted opB + C. Both assert `writeDest` while `en` is high.
- R2: Opcode 2 gives opA − shifted opB. Opcode 3 gives opA − shifted opB − (1 − C). Both assert `writeDest`.
- R3: Opcode 4 gives shifted opB − opA and asserts `writeDest`.
- R4: Operand 2 is opB shifted left by `shiftAmt` (0 to 31), with zeros filled in from the right.
- R5: Opcode 5 gives opA AND shifted opB. Opcode 6 gives opA XOR shifted opB. Both assert `writeDest`.
- R6: For the add forms (opcodes 0, 1 and 8), the new C (`flags[1]`) is the carry out of bit 31. For the subtract forms (opcodes 2, 3, 4 and 7), the new C is 1 when no borrow occurs.
- R7: For the add and subtract forms, the new V (`flags[0]`) is two's-complement signed overflow of the operation.
- R8: Whenever the flags update, N (`flags[3]`) becomes bit 31 of the computed value. Z (`flags[2]`) becomes 1 exactly when all 32 bits of that value are zero.
- R9: The four compare/test opcodes are 7 (opA − opB), 8 (opA + opB), 9 (AND) and 10 (XOR). While `en` is high, they always update the flags and never assert `writeDest`.
- R10: Opcodes 0 to 6 update the flags only when `setFlags` is 1. Otherwise the flags hold their value.
- R11: For opcodes 5, 6, 9 and 10, a nonzero shift makes C the last bit shifted out of opB. A zero shift leaves C unchanged. V is always unchanged for these opcodes.
- R12: Reset, which is active low, clears the flags to 0000. With `en` low, or with opcode 11 to 15, there is no destination write and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the flags |
| en | input | 1 | Instruction valid this cycle |
| opCode | input | 4 | Operation select (0 to 10 defined) |
| setFlags | input | 1 | Flag-update request for opcodes 0 to 6 |
| opA | input | 32 | Operand 1 |
| opB | input | 32 | Operand 2 before the shift |
| shiftAmt | input | 5 | Left-shift amount applied to opB |
| result | output | 32 | Computed value |
| writeDest | output | 1 | Destination write enable |
| flags | output | 4 | Registered NZCV, N in bit 3 |

## Verification
Several properties are checked by the assertions on every clock, whatever the stimulus:
- The flags hold whenever no update is requested.
- N and Z track the value that was just computed.
- Bitwise operations leave V untouched, and leave C untouched when the shift is zero.
- A compare/test opcode never raises `writeDest`.

Other behaviour needs known operand values, so only the bench scenarios can show it:
- the arithmetic values themselves;
- carry as not-borrow;
- chained carries in 64-bit add and subtract sequences;
- the carry bit shifted out of opB;
- signed overflow at the 0x7FFFFFFF boundary.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
    OP_RSB = 4'd4, OP_AND = 4'd5, OP_EOR = 4'd6, OP_CMP = 4'd7,
    OP_CMN = 4'd8, OP_TST = 4'd9, OP_TEQ = 4'd10
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cinSel_e;

  typedef struct packed {
    logic    invA;
    logic    invB;
    cinSel_e cinSel;
    logic    selLogic;
    logic    logicXor;
    logic    wrDest;
    logic    updFlags;
  } aluStrobes_t;

endpackage

// File: rtl/flag_alu_lsl.sv
module flag_alu_lsl #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] dout,
  output logic              carryOut
);
  logic [DATA_W:0] wide;

  // One extra bit on top catches the last bit pushed out.
  assign wide     = {1'b0, din} << amt;
  assign dout     = wide[DATA_W-1:0];
  assign carryOut = (amt != '0) ? wide[DATA_W] : 1'b0;
endmodule

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic        en,
  input  logic [3:0]  opCode,
  input  logic        setFlags,
  output aluStrobes_t strb
);
  always_comb begin
    strb = '{invA: 1'b0, invB: 1'b0, cinSel: CIN_ZERO, selLogic: 1'b0,
             logicXor: 1'b0, wrDest: 1'b0, updFlags: 1'b0};
    if (en) begin
      case (opCode)
        OP_ADD: begin strb.wrDest = 1'b1; strb.updFlags = setFlags; end
        OP_ADC: begin strb.cinSel = CIN_FLAG; strb.wrDest = 1'b1; strb.updFlags = setFlags; end
        OP_SUB: begin strb.invB = 1'b1; strb.cinSel = CIN_ONE; strb.wrDest = 1'b1; strb.updFlags = setFlags; end
        OP_SBC: begin strb.invB = 1'b1; strb.cinSel = CIN_FLAG; strb.wrDest = 1'b1; strb.updFlags = setFlags; end
        OP_RSB: begin strb.invA = 1'b1; strb.cinSel = CIN_ONE; strb.wrDest = 1'b1; strb.updFlags = setFlags; end
        OP_AND: begin strb.selLogic = 1'b1; strb.wrDest = 1'b1; strb.updFlags = setFlags; end
        OP_EOR: begin strb.selLogic = 1'b1; strb.logicXor = 1'b1; strb.wrDest = 1'b1; strb.updFlags = setFlags; end
        OP_CMP: begin strb.invB = 1'b1; strb.cinSel = CIN_ONE; strb.updFlags = 1'b1; end
        OP_CMN: begin strb.updFlags = 1'b1; end
        OP_TST: begin strb.selLogic = 1'b1; strb.updFlags = 1'b1; end
        OP_TEQ: begin strb.selLogic = 1'b1; strb.logicXor = 1'b1; strb.updFlags = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flag_alu_dpath.sv
module flag_alu_dpath
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobes_t       strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SH_W-1:0]   shiftAmt,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flagsQ
);
  logic [DATA_W-1:0] shB, aIn, bIn, logicRes;
  logic [DATA_W:0]   sum;
  logic              shCarry, cin, arithV;
  logic [3:0]        flagsNext;

  flag_alu_lsl #(.DATA_W(DATA_W)) uLsl (
    .din(opB), .amt(shiftAmt), .dout(shB), .carryOut(shCarry)
  );

  // Shared adder: subtract forms invert one side and feed carry-in.
  assign aIn = strb.invA ? ~opA : opA;
  assign bIn = strb.invB ? ~shB : shB;

  always_comb begin
    case (strb.cinSel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = flagsQ[FLAG_C];
      default:  cin = 1'b0;
    endcase
  end

  assign sum      = {1'b0, aIn} + {1'b0, bIn} + {{DATA_W{1'b0}}, cin};
  assign arithV   = (aIn[DATA_W-1] == bIn[DATA_W-1]) && (sum[DATA_W-1] != aIn[DATA_W-1]);
  assign logicRes = strb.logicXor ? (opA ^ shB) : (opA & shB);
  assign result   = strb.selLogic ? logicRes : sum[DATA_W-1:0];

  always_comb begin
    flagsNext[FLAG_N] = result[DATA_W-1];
    flagsNext[FLAG_Z] = (result == '0);
    if (strb.selLogic) begin
      flagsNext[FLAG_C] = (shiftAmt != '0) ? shCarry : flagsQ[FLAG_C];
      flagsNext[FLAG_V] = flagsQ[FLAG_V];
    end else begin
      flagsNext[FLAG_C] = sum[DATA_W];
      flagsNext[FLAG_V] = arithV;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              flagsQ <= '0;
    else if (strb.updFlags) flagsQ <= flagsNext;
  end

  assert_hold_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.updFlags |=> $stable(flagsQ));

  assert_nz_track_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.updFlags |=> (flagsQ[FLAG_N] == $past(result[DATA_W-1])) &&
                      (flagsQ[FLAG_Z] == ($past(result) == '0)));

  assert_logic_v_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.updFlags && strb.selLogic) |=> $stable(flagsQ[FLAG_V]));

  assert_logic_c_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.updFlags && strb.selLogic && shiftAmt == '0) |=> $stable(flagsQ[FLAG_C]));
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [3:0]        opCode,
  input  logic              setFlags,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SH_W-1:0]   shiftAmt,
  output logic [DATA_W-1:0] result,
  output logic              writeDest,
  output logic [3:0]        flags
);
  aluStrobes_t strb;

  flag_alu_ctrl uCtrl (
    .en(en), .opCode(opCode), .setFlags(setFlags), .strb(strb)
  );

  flag_alu_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .shiftAmt(shiftAmt), .result(result), .flagsQ(flags)
  );

  assign writeDest = strb.wrDest;

  assert_cmp_nowrite_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opCode >= 4'd7 && opCode <= 4'd10) |-> !writeDest);

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!en || opCode > 4'd10) |=> $stable(flags));
endmodule

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  opCode = '0;
  logic        setFlags = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [4:0]  shiftAmt = '0;
  logic [31:0] result;
  logic        writeDest;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [3:0] mFlags = 4'b0000;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  flag_alu u0 (
    .clk(clk), .rstN(rstN), .en(en), .opCode(opCode), .setFlags(setFlags),
    .opA(opA), .opB(opB), .shiftAmt(shiftAmt),
    .result(result), .writeDest(writeDest), .flags(flags)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: returns value, write request, update request, new flags.
  task automatic model(input logic [3:0] op, input logic s, input logic e,
                       input logic [31:0] a, input logic [31:0] b, input int sh,
                       input logic [3:0] fl, output logic [31:0] res,
                       output logic wr, output logic upd, output logic [3:0] nf);
    longint unsigned ua, ub, tot;
    logic [31:0] b2;
    logic c, v, borrow, known;
    b2 = b << sh;
    ua = a; ub = b2;
    c = fl[1]; v = fl[0]; res = 0; known = 1'b1;
    borrow = !fl[1];
    case (op)
      0, 1, 8: begin
        tot = ua + ub + ((op == 1) ? longint'(fl[1]) : 0);
        res = tot[31:0]; c = tot[32];
        v = (a[31] == b2[31]) && (res[31] != a[31]);
      end
      2, 7: begin
        res = a - b2; c = (ua >= ub);
        v = (a[31] != b2[31]) && (res[31] != a[31]);
      end
      3: begin
        res = a - b2 - {31'd0, borrow}; c = (ua >= ub + longint'(borrow));
        v = (a[31] != b2[31]) && (res[31] != a[31]);
      end
      4: begin
        res = b2 - a; c = (ub >= ua);
        v = (a[31] != b2[31]) && (res[31] != b2[31]);
      end
      5, 9, 6, 10: begin
        res = (op == 5 || op == 9) ? (a & b2) : (a ^ b2);
        if (sh != 0) c = b[32 - sh];
      end
      default: known = 1'b0;
    endcase
    wr  = e && known && op <= 6;
    upd = e && known && ((op >= 7) || s);
    nf  = upd ? {res[31], res == 0, c, v} : fl;
  endtask

  task automatic exec(input string tag, input logic [3:0] op, input logic s, input logic e,
                      input logic [31:0] a, input logic [31:0] b, input int sh);
    logic [31:0] eRes;
    logic eWr, eUpd;
    logic [3:0] eFl;
    @(negedge clk);
    opCode = op; setFlags = s; en = e; opA = a; opB = b; shiftAmt = sh[4:0];
    #2;
    model(op, s, e, a, b, sh, mFlags, eRes, eWr, eUpd, eFl);
    if (eWr) check({tag, " result"}, result, eRes);
    check({tag, " writeDest"}, {31'd0, writeDest}, {31'd0, eWr});
    @(posedge clk);
    #1;
    mFlags = eFl;
    check({tag, " flags"}, {28'd0, flags}, {28'd0, mFlags});
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset flags", {28'd0, flags}, 32'd0);
    @(negedge clk); rstN = 1'b1;

    // R2 R6 R8: 1 - 1 gives zero, Z and C set
    exec("R2 subs", 4'd2, 1'b1, 1'b1, 32'd1, 32'd1, 0);
    check("R6 R8 subs flags", {28'd0, flags}, 32'b0110);
    // R3: 0 - 0x77
    exec("R3 rsb", 4'd4, 1'b0, 1'b1, 32'h77, 32'd0, 0);
    check("R3 rsb value", result, 32'hFFFF_FF89);
    // R4: 5 + (5 << 1)
    exec("R4 add shifted", 4'd0, 1'b0, 1'b1, 32'd5, 32'd5, 1);
    check("R4 add shifted value", result, 32'hF);
    // R1: 64-bit add chain
    exec("R1 adds low", 4'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'd1, 0);
    check("R6 carry out", {31'd0, flags[1]}, 32'd1);
    exec("R1 adc high", 4'd1, 1'b0, 1'b1, 32'd1, 32'd2, 0);
    check("R1 adc value", result, 32'd4);
    // R2: 64-bit subtract chain with borrow
    exec("R2 subs low", 4'd2, 1'b1, 1'b1, 32'd0, 32'd1, 0);
    check("R6 borrow clears C", {31'd0, flags[1]}, 32'd0);
    exec("R2 sbc high", 4'd3, 1'b0, 1'b1, 32'd5, 32'd2, 0);
    check("R2 sbc value", result, 32'd2);
    // R9: compare equal, no write, flags updated without setFlags
    exec("R9 cmp", 4'd7, 1'b0, 1'b1, 32'd4, 32'd4, 0);
    check("R9 cmp flags", {28'd0, flags}, 32'b0110);
    check("R9 cmp no write", {31'd0, writeDest}, 32'd0);
    // R10: add without setFlags keeps flags
    exec("R10 add noS", 4'd0, 1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, 0);
    check("R10 flags held", {28'd0, flags}, 32'b0110);
    // R7: signed overflow
    exec("R7 adds ovf", 4'd0, 1'b1, 1'b1, 32'h7FFF_FFFF, 32'd1, 0);
    check("R7 flags", {28'd0, flags}, 32'b1001);
    // R11: logical with zero shift keeps C and V
    exec("R11 ands", 4'd5, 1'b1, 1'b1, 32'hF0, 32'h0F, 0);
    check("R11 ands flags", {28'd0, flags}, 32'b0101);
    exec("R11 eors shifted", 4'd6, 1'b1, 1'b1, 32'd0, 32'h8000_0001, 1);
    check("R5 R11 eors value", result, 32'd2);
    check("R11 eors flags", {28'd0, flags}, 32'b0011);
    // R9: test and test-equal
    exec("R9 tst", 4'd9, 1'b0, 1'b1, 32'hFF, 32'h100, 0);
    exec("R9 teq", 4'd10, 1'b0, 1'b1, 32'hAA, 32'hAA, 0);
    exec("R9 cmn", 4'd8, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'd1, 0);
    // R12: idle and undefined opcodes
    exec("R12 en low", 4'd2, 1'b1, 1'b0, 32'd3, 32'd9, 0);
    exec("R12 bad op", 4'd13, 1'b1, 1'b1, 32'd3, 32'd9, 0);

    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      logic [31:0] a, b;
      op = 4'($urandom_range(0, 15));
      a = $urandom;
      b = $urandom;
      if ((i % 7) == 0) a = 32'h8000_0000 - 32'($urandom_range(0, 2));
      if ((i % 11) == 0) b = a;
      exec("R1 R5 R6 R7 R8 random", op, 1'($urandom), ($urandom_range(0, 9) != 0),
           a, b, (i % 3 == 0) ? 0 : int'($urandom_range(0, 31)));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule